// File: doc/BRIEF.md
# Write-Miss Allocation Sequencer

This controller-side sequencer handles a processor write that misses the cache. When the miss is found, the write is handed to an empty memory-cycle buffer and the processor gets its ready in the lookup cycle, with no wait state. The sequencer then places a write-through request on the memory bus. With that request it marks that it will source the processor ready strobes itself, and that an allocate cycle may follow. After the bus controller takes the request, the sequencer issues no further bus request until the allocate decision has been sampled in its window strobe. The bus controller may report that it is free before then, and this does not change. If the decision grants allocation, the sequencer pulses an allocate strobe to the data path and issues a line-fill request. It then follows that request through bus grant and completion.

The block has two state machines. The processor side (`C_IDLE`, `C_TURN`, `C_LOOKUP`, `C_HOLD`, `C_FINISH`, `C_LATE_RDY`) raises next-address during the lookup cycle, whatever the lookup result turns out to be. It completes read hits even while the bus side is busy. It inserts `WAR_WAIT` wait states (`C_IDLE`→`C_TURN`→`C_LOOKUP`) when a write follows a read ready back to back. It parks a later write miss in `C_HOLD`:
- If allocation is refused, the bus goes idle and the parked write is completed and posted as its own write-through.
- If allocation is granted, the parked write goes `C_HOLD`→`C_FINISH` at the grant and `C_FINISH`→`C_LATE_RDY` at completion, then returns a late ready with no bus cycle of its own.

The bus side has the states `B_IDLE`, `B_WT_REQ`, `B_RESOLVE`, `B_FILL_REQ`, `B_WAIT_GNT` and `B_WAIT_DONE`, with these transitions:
- `B_IDLE`→`B_WT_REQ` when a write miss starts.
- Each request state moves on when the bus controller accepts the request.
- `B_RESOLVE`→`B_FILL_REQ` or `B_IDLE` at the window strobe.
- `B_WAIT_GNT`→`B_WAIT_DONE` on grant.
- `B_WAIT_DONE`→`B_IDLE` on completion.

All inputs and outputs are active high.

Top module: `wmiss_alloc_seq`

## Requirements
- R1: While reset is active, and immediately after an asynchronous reset taken mid-transaction, every output is 0. After reset the sequencer accepts a new request.
- R2: A request (`cpu_req`=1 for one cycle in idle) gives `cpu_next_addr`=1 in the following cycle, the lookup cycle. This holds for hits and misses alike.
- R3: In the lookup cycle, a hit (read or write) gives `cpu_rdy`=1 and a read miss gives `cpu_rdy`=0 with no bus activity. A write miss while the bus side is idle gives `cpu_rdy`=1 and `dp_mem_cycle`=1 in that same cycle.
- R4: The cycle after a posted write miss, `mb_req`=1 with `mb_req_fill`=0 (write-through), `mb_rdy_self`=1 and `mb_alloc_may`=1. Any request stays asserted, with its type unchanged, until a cycle in which `mb_free`=1.
- R5: After a write-through request is accepted, `mb_req` stays 0 until the window strobe has been seen, even while `mb_free`=1.
- R6: In the cycle where `mb_win`=1 and `mb_alloc_ok`=1 after a write-through, `dp_alloc_pulse`=1. In the next cycle `mb_req`=1 with `mb_req_fill`=1 (line fill).
- R7: If `mb_alloc_ok`=0 in the window, no allocate pulse and no line fill follow, and the bus side returns to idle. A value of `mb_alloc_ok` outside the window has no effect.
- R8: A write miss found while an allocation is pending gets no ready until the allocation completes. Its `cpu_rdy`=1 comes exactly one cycle after the `mb_done` cycle, and it issues no bus request of its own.
- R9: A write miss held behind a write-through whose allocation is refused gets `cpu_rdy`=1 and `dp_mem_cycle`=1 in the cycle after the bus side returns to idle. Its own write-through request follows in the next cycle.
- R10: A read hit looked up while the bus side is busy gets `cpu_rdy`=1 in its lookup cycle.
- R11: A write request in the idle cycle right after a read ready waits `WAR_WAIT` (default 1) extra cycles before its lookup cycle. A write after a read miss does not wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request start, one cycle, taken only in idle |
| cpu_wr | input | 1 | Request is a write (1) or a read (0), sampled with cpu_req |
| lkup_hit | input | 1 | Tag lookup result, valid in the lookup cycle |
| cpu_next_addr | output | 1 | Next-address indication to the processor |
| cpu_rdy | output | 1 | Ready to the processor |
| dp_mem_cycle | output | 1 | Marks to the data path that the cycle uses the memory bus |
| dp_alloc_pulse | output | 1 | Allocate notification to the data path |
| mb_req | output | 1 | Memory bus request |
| mb_req_fill | output | 1 | Request type: 1 line fill, 0 write-through |
| mb_rdy_self | output | 1 | This block sources the processor ready strobes |
| mb_alloc_may | output | 1 | An allocate cycle may follow this write |
| mb_free | input | 1 | Bus controller can accept a request |
| mb_win | input | 1 | Sample window for the allocate decision |
| mb_alloc_ok | input | 1 | Allocate decision, meaningful only with mb_win |
| mb_grant | input | 1 | Bus grant of the line fill |
| mb_done | input | 1 | Completion ready of the line fill |

## Verification
The hardest situation to reach is a second write miss parked in `C_HOLD` while the first write's allocation passes through its window, grant and completion. The lookup of the second write has to land after the write-through is accepted and before the window. The bench therefore keeps `mb_free` high from the start, fires the second request two cycles into `B_RESOLVE`, and only then drives the window, grant and completion one cycle apart. This lets the late ready be pinned to the cycle after completion. The same staging, with the allocate decision refused, reaches the path where the held write launches its own write-through.

// File: rtl/wmas_pkg.sv
package wmas_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_TURN,
        C_LOOKUP,
        C_HOLD,
        C_FINISH,
        C_LATE_RDY
    } cpu_st_e;

    typedef enum logic [2:0] {
        B_IDLE,
        B_WT_REQ,
        B_RESOLVE,
        B_FILL_REQ,
        B_WAIT_GNT,
        B_WAIT_DONE
    } bus_st_e;

endpackage

// File: rtl/wmas_bus_side.sv
module wmas_bus_side
    import wmas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mb_free,
    input  logic mb_win,
    input  logic mb_alloc_ok,
    input  logic mb_grant,
    input  logic mb_done,
    output logic mb_req,
    output logic mb_req_fill,
    output logic mb_rdy_self,
    output logic mb_alloc_may,
    output logic dp_alloc_pulse,
    output logic bus_idle,
    output logic alloc_granted
);

    bus_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= B_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            B_IDLE:      if (start)    st_d = B_WT_REQ;
            B_WT_REQ:    if (mb_free)  st_d = B_RESOLVE;
            B_RESOLVE:   if (mb_win)   st_d = mb_alloc_ok ? B_FILL_REQ : B_IDLE;
            B_FILL_REQ:  if (mb_free)  st_d = B_WAIT_GNT;
            B_WAIT_GNT:  if (mb_grant) st_d = B_WAIT_DONE;
            B_WAIT_DONE: if (mb_done)  st_d = B_IDLE;
            default:                   st_d = B_IDLE;
        endcase
    end

    always_comb begin
        mb_req         = (st_q == B_WT_REQ) || (st_q == B_FILL_REQ);
        mb_req_fill    = (st_q == B_FILL_REQ);
        mb_rdy_self    = (st_q == B_WT_REQ);
        mb_alloc_may   = (st_q == B_WT_REQ);
        dp_alloc_pulse = (st_q == B_RESOLVE) && mb_win && mb_alloc_ok;
        bus_idle       = (st_q == B_IDLE);
        alloc_granted  = (st_q == B_WAIT_DONE);
    end

endmodule

// File: rtl/wmas_cpu_side.sv
module wmas_cpu_side
    import wmas_pkg::*;
#(
    parameter int unsigned WAR_WAIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_wr,
    input  logic lkup_hit,
    input  logic bus_idle,
    input  logic alloc_granted,
    input  logic mb_done,
    output logic cpu_next_addr,
    output logic cpu_rdy,
    output logic start
);

    localparam int unsigned TCW       = (WAR_WAIT > 1) ? $clog2(WAR_WAIT) : 1;
    localparam int unsigned TURN_LAST = (WAR_WAIT > 0) ? WAR_WAIT - 1 : 0;
    localparam bit          USE_TURN  = (WAR_WAIT != 0);

    cpu_st_e        st_q, st_d;
    logic           wr_q;
    logic           rd_done_q;
    logic [TCW-1:0] turn_cnt_q;
    logic           read_rdy;
    cpu_st_e        miss_next;

    // where a write miss goes when the bus side may be busy
    always_comb begin
        if (bus_idle)                      miss_next = C_IDLE;
        else if (alloc_granted && mb_done) miss_next = C_LATE_RDY;
        else if (alloc_granted)            miss_next = C_FINISH;
        else                               miss_next = C_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= C_IDLE;
            wr_q       <= 1'b0;
            rd_done_q  <= 1'b0;
            turn_cnt_q <= '0;
        end else begin
            st_q      <= st_d;
            rd_done_q <= read_rdy;
            if (st_q == C_IDLE && cpu_req) wr_q <= cpu_wr;
            if (st_q == C_TURN) turn_cnt_q <= turn_cnt_q + 1'b1;
            else                turn_cnt_q <= '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_IDLE: begin
                if (cpu_req)
                    st_d = (USE_TURN && cpu_wr && rd_done_q) ? C_TURN : C_LOOKUP;
            end
            C_TURN: begin
                if (turn_cnt_q == TCW'(TURN_LAST)) st_d = C_LOOKUP;
            end
            C_LOOKUP: begin
                if (wr_q && !lkup_hit) st_d = miss_next;
                else                   st_d = C_IDLE;
            end
            C_HOLD:     st_d = miss_next;
            C_FINISH:   if (mb_done) st_d = C_LATE_RDY;
            C_LATE_RDY: st_d = C_IDLE;
            default:    st_d = C_IDLE;
        endcase
    end

    always_comb begin
        cpu_next_addr = (st_q == C_LOOKUP);
        read_rdy      = (st_q == C_LOOKUP) && !wr_q && lkup_hit;
        start         = ((st_q == C_LOOKUP) && wr_q && !lkup_hit && bus_idle)
                      || ((st_q == C_HOLD) && bus_idle);
        cpu_rdy       = ((st_q == C_LOOKUP) && (lkup_hit || (wr_q && bus_idle)))
                      || ((st_q == C_HOLD) && bus_idle)
                      || (st_q == C_LATE_RDY);
    end

endmodule

// File: rtl/wmiss_alloc_seq.sv
module wmiss_alloc_seq #(
    parameter int unsigned WAR_WAIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_wr,
    input  logic lkup_hit,
    output logic cpu_next_addr,
    output logic cpu_rdy,
    output logic dp_mem_cycle,
    output logic dp_alloc_pulse,
    output logic mb_req,
    output logic mb_req_fill,
    output logic mb_rdy_self,
    output logic mb_alloc_may,
    input  logic mb_free,
    input  logic mb_win,
    input  logic mb_alloc_ok,
    input  logic mb_grant,
    input  logic mb_done
);

    logic start;
    logic bus_idle;
    logic alloc_granted;

    wmas_cpu_side #(.WAR_WAIT(WAR_WAIT)) cpu_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_wr        (cpu_wr),
        .lkup_hit      (lkup_hit),
        .bus_idle      (bus_idle),
        .alloc_granted (alloc_granted),
        .mb_done       (mb_done),
        .cpu_next_addr (cpu_next_addr),
        .cpu_rdy       (cpu_rdy),
        .start         (start)
    );

    wmas_bus_side bus_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .mb_free        (mb_free),
        .mb_win         (mb_win),
        .mb_alloc_ok    (mb_alloc_ok),
        .mb_grant       (mb_grant),
        .mb_done        (mb_done),
        .mb_req         (mb_req),
        .mb_req_fill    (mb_req_fill),
        .mb_rdy_self    (mb_rdy_self),
        .mb_alloc_may   (mb_alloc_may),
        .dp_alloc_pulse (dp_alloc_pulse),
        .bus_idle       (bus_idle),
        .alloc_granted  (alloc_granted)
    );

    assign dp_mem_cycle = start;

endmodule

// File: rtl/wmiss_alloc_seq_chk.sv
module wmiss_alloc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_rdy,
    input logic dp_mem_cycle,
    input logic dp_alloc_pulse,
    input logic mb_req,
    input logic mb_req_fill,
    input logic mb_rdy_self,
    input logic mb_alloc_may,
    input logic mb_free,
    input logic mb_win,
    input logic mb_alloc_ok
);

    assert_memcyc_with_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dp_mem_cycle |-> cpu_rdy);

    assert_wt_qualifiers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_req_fill) |-> (mb_rdy_self && mb_alloc_may));

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && !mb_free) |=> (mb_req && $stable(mb_req_fill)));

    assert_quiet_after_wt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_req && mb_free && !mb_req_fill) |=> !mb_req);

    assert_pulse_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_alloc_pulse |-> (mb_win && mb_alloc_ok));

    assert_fill_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_alloc_pulse |=> (mb_req && mb_req_fill));

endmodule

bind wmiss_alloc_seq wmiss_alloc_seq_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_rdy        (cpu_rdy),
    .dp_mem_cycle   (dp_mem_cycle),
    .dp_alloc_pulse (dp_alloc_pulse),
    .mb_req         (mb_req),
    .mb_req_fill    (mb_req_fill),
    .mb_rdy_self    (mb_rdy_self),
    .mb_alloc_may   (mb_alloc_may),
    .mb_free        (mb_free),
    .mb_win         (mb_win),
    .mb_alloc_ok    (mb_alloc_ok)
);

// File: tb/wmiss_alloc_seq_tb_top.sv
`timescale 1ns/1ps
module wmiss_alloc_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 0, cpu_wr = 0, lkup_hit = 0;
    logic mb_free = 0, mb_win = 0, mb_alloc_ok = 0, mb_grant = 0, mb_done = 0;
    logic cpu_next_addr, cpu_rdy, dp_mem_cycle, dp_alloc_pulse;
    logic mb_req, mb_req_fill, mb_rdy_self, mb_alloc_may;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    wmiss_alloc_seq #(.WAR_WAIT(1)) dut_i (.*);

    // {wr, hit, alloc, exp_rdy, exp_bus, exp_fill}
    localparam int NV = 6;
    localparam logic [5:0] VEC [NV] = '{
        6'b011_100,   // read hit
        6'b000_000,   // read miss
        6'b110_100,   // write hit
        6'b101_111,   // write miss, allocation granted
        6'b100_110,   // write miss, allocation refused
        6'b101_111    // write miss, allocation granted again
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic outs_zero(input string tag);
        chk({tag, " next_addr"}, cpu_next_addr, 1'b0);
        chk({tag, " rdy"}, cpu_rdy, 1'b0);
        chk({tag, " mem_cycle"}, dp_mem_cycle, 1'b0);
        chk({tag, " alloc_pulse"}, dp_alloc_pulse, 1'b0);
        chk({tag, " req"}, mb_req, 1'b0);
        chk({tag, " fill"}, mb_req_fill, 1'b0);
        chk({tag, " rdy_self"}, mb_rdy_self, 1'b0);
        chk({tag, " alloc_may"}, mb_alloc_may, 1'b0);
    endtask

    task automatic issue(input logic wr, input logic hit);
        cpu_req = 1'b1; cpu_wr = wr; lkup_hit = hit;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic run_vec(input logic [5:0] v);
        repeat (2) @(negedge clk);
        mb_free = 1'b0;
        issue(v[5], v[4]);
        chk("R2 next_addr in lookup", cpu_next_addr, 1'b1);
        chk("R3 lookup rdy", cpu_rdy, v[2]);
        chk("R3 mem_cycle", dp_mem_cycle, v[1]);
        @(negedge clk);
        chk("R4 write-through req", mb_req, v[1]);
        if (v[1]) begin
            chk("R4 type write-through", mb_req_fill, 1'b0);
            chk("R4 self ready", mb_rdy_self, 1'b1);
            chk("R4 alloc may follow", mb_alloc_may, 1'b1);
            @(negedge clk);
            chk("R4 req held", mb_req, 1'b1);
            mb_free = 1'b1;
            @(negedge clk);
            chk("R5 no req while unresolved", mb_req, 1'b0);
            mb_alloc_ok = 1'b1;               // outside window: no effect
            @(negedge clk);
            chk("R5 no req with bus free", mb_req, 1'b0);
            chk("R7 alloc_ok outside window ignored", dp_alloc_pulse, 1'b0);
            mb_win = 1'b1; mb_alloc_ok = v[3];
            #1;
            chk("R6 alloc pulse in window", dp_alloc_pulse, v[0]);
            @(negedge clk);
            mb_win = 1'b0; mb_alloc_ok = 1'b0;
            chk("R6 fill req", mb_req, v[0]);
            chk("R6 fill type", mb_req_fill, v[0]);
            if (v[0]) begin
                @(negedge clk);
                chk("R6 fill accepted", mb_req, 1'b0);
                mb_grant = 1'b1;
                @(negedge clk);
                mb_grant = 1'b0; mb_done = 1'b1;
                @(negedge clk);
                mb_done = 1'b0;
            end
            chk("R7 bus quiet after sequence", mb_req, 1'b0);
        end
        mb_free = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        outs_zero("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R1: reset in the middle of a held write-through request
        repeat (2) @(negedge clk);
        mb_free = 1'b0;
        issue(1'b1, 1'b0);
        @(negedge clk);
        chk("R1 pre-reset req", mb_req, 1'b1);
        rst_n = 1'b0;
        #1;
        outs_zero("R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b0, 1'b1);
        chk("R1 accepts after reset", cpu_rdy, 1'b1);

        // R10 / R8: read hit and dependent write miss during allocation
        repeat (2) @(negedge clk);
        mb_free = 1'b1;
        issue(1'b1, 1'b0);                    // write miss A, lookup
        @(negedge clk);                       // B_WT_REQ, accepted
        @(negedge clk);                       // B_RESOLVE
        issue(1'b0, 1'b1);                    // read hit lookup
        chk("R10 read hit while busy", cpu_rdy, 1'b1);
        repeat (2) @(negedge clk);
        issue(1'b1, 1'b0);                    // write miss B lookup
        chk("R8 no rdy at lookup", cpu_rdy, 1'b0);
        chk("R8 next_addr", cpu_next_addr, 1'b1);
        @(negedge clk);                       // C_HOLD
        chk("R8 held", cpu_rdy, 1'b0);
        mb_win = 1'b1; mb_alloc_ok = 1'b1;
        @(negedge clk);                       // B_FILL_REQ
        mb_win = 1'b0; mb_alloc_ok = 1'b0;
        chk("R8 held in fill", cpu_rdy, 1'b0);
        @(negedge clk);                       // B_WAIT_GNT
        mb_grant = 1'b1;
        @(negedge clk);                       // B_WAIT_DONE
        mb_grant = 1'b0;
        mb_done = 1'b1;
        #1;
        chk("R8 no rdy in done cycle", cpu_rdy, 1'b0);
        @(negedge clk);
        mb_done = 1'b0;
        chk("R8 late rdy after done", cpu_rdy, 1'b1);
        chk("R8 no own request", mb_req, 1'b0);
        @(negedge clk);
        chk("R8 single rdy", cpu_rdy, 1'b0);
        chk("R8 still no request", mb_req, 1'b0);

        // R9: held write when allocation refused
        repeat (2) @(negedge clk);
        issue(1'b1, 1'b0);                    // write miss A
        @(negedge clk);                       // accepted
        @(negedge clk);                       // B_RESOLVE
        issue(1'b1, 1'b0);                    // write miss B lookup
        chk("R9 held at lookup", cpu_rdy, 1'b0);
        mb_win = 1'b1; mb_alloc_ok = 1'b0;
        @(negedge clk);                       // bus idle, C_HOLD
        mb_win = 1'b0;
        chk("R9 rdy when bus idle", cpu_rdy, 1'b1);
        chk("R9 mem_cycle", dp_mem_cycle, 1'b1);
        @(negedge clk);
        chk("R9 own write-through", mb_req, 1'b1);
        chk("R9 type write-through", mb_req_fill, 1'b0);
        @(negedge clk);                       // B_RESOLVE
        mb_win = 1'b1;
        @(negedge clk);
        mb_win = 1'b0; mb_free = 1'b0;

        // R11: write-after-read wait state, and control after a read miss
        repeat (2) @(negedge clk);
        issue(1'b0, 1'b1);                    // read hit lookup
        chk("R11 read rdy", cpu_rdy, 1'b1);
        @(negedge clk);                       // idle, read just completed
        issue(1'b1, 1'b1);
        chk("R11 turn cycle no next_addr", cpu_next_addr, 1'b0);
        chk("R11 turn cycle no rdy", cpu_rdy, 1'b0);
        @(negedge clk);
        chk("R11 delayed next_addr", cpu_next_addr, 1'b1);
        chk("R11 delayed rdy", cpu_rdy, 1'b1);
        repeat (2) @(negedge clk);
        issue(1'b0, 1'b0);                    // read miss
        chk("R3 read miss no rdy", cpu_rdy, 1'b0);
        @(negedge clk);
        issue(1'b1, 1'b1);
        chk("R11 no wait after read miss", cpu_next_addr, 1'b1);
        chk("R11 rdy after read miss", cpu_rdy, 1'b1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule